// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Controller

This block is the register core behind a four-channel digital-to-analog converter. Every channel keeps two copies of its setting: an input buffer, which commands write, and an active buffer, which drives the converter. Each copy holds a 16-bit code and a 4-bit span. An update copies input buffers into active buffers. The next value can therefore be staged while the present one is still on the outputs.

Commands arrive on a parallel interface: a valid strobe, an opcode, an address and a data word. They are framed by an active-low frame level. The command captured during a frame runs when the frame closes. Other inputs act on the buffers directly: a clear, a brownout indication, an asynchronous load and a manual-span mode with four strap pins. An active-low integrity flag tells the system when the outputs may not match what it last loaded. A readback port shows any channel's input buffer and whether that buffer can be trusted.

A sequencer built as a state machine handles the framing. It has four states:
- **IDLE** waits for a frame.
- **FRAME** captures commands.
- **ABORT** holds after a clear has cut a frame short.
- **EXEC** lasts one cycle and runs the command.

It has these transitions:
- IDLE→FRAME when the frame goes low.
- IDLE→ABORT when the frame goes low while clear is low.
- FRAME→ABORT when clear goes low.
- FRAME→EXEC when the frame rises after a command was captured.
- FRAME→IDLE when the frame rises with no command captured.
- ABORT→IDLE when the frame rises.
- EXEC→IDLE unconditionally.

Top module: `quad_dac_regcore`

## Requirements
- R1: After reset, every active span and every input span reads 4'b0000, the unipolar 0-to-5 V range.
- R2: After reset, all active and input codes are zero, and every input buffer reads back as valid (`rb_valid`=1).
- R3: The opcodes are 0 no-op, 1 write input code, 2 write input span (data[3:0]), 3 update, 4 write-and-update. Opcodes 5 to 7 do nothing. Opcodes 1 and 2 change only the input buffer. The outputs keep their values until an update.
- R4: A command runs only when the frame rises (a 0→1 edge of `frame_n`) after it was captured while the frame was low. Addresses 0 to 3 select one channel and address 4 selects all four. Addresses 5 to 7 select none. An update copies the input code and span of each selected channel into its active buffer. Write-and-update writes the code and then updates, both in the same execution.
- R5: While `clr_n` is low, every active code and span is forced to zero. No input buffer changes.
- R6: An update after a clear, whether it comes from a command or from the load input, restores the preserved input values of the channels it addresses.
- R7: A falling edge on `load_n`, passed through a two-stage synchronizer, updates all four channels.
- R8: While `span_manual` is 1, every update sets the active span of all four channels to `span_strap`. Codes are still taken only for the addressed channels.
- R9: If `clr_n` goes low while a frame is open, the captured command is discarded. The input buffers it addressed read back with `rb_valid`=0 until they are written again.
- R10: `integrity_n` is 0 after reset, after any cycle with `clr_n` low, and after any cycle with `brownout` high.
- R11: `integrity_n` returns to 1 only after a valid update: opcode 3 or 4 with address 0 to 4, or a load edge. No-ops, writes and updates to addresses 5 to 7 leave it low.
- R12: A clear in the same cycle as an update wins. The active buffers stay zero and `integrity_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| frame_n | input | 1 | Instruction frame, low while a command is in progress |
| cmd_valid | input | 1 | Command fields valid this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | 3 | Channel address, 4 = all channels |
| cmd_data | input | 16 | Code, or span in bits 3:0 |
| clr_n | input | 1 | System clear, active low |
| brownout | input | 1 | Supply below threshold |
| load_n | input | 1 | Asynchronous load, falling edge updates all channels |
| span_manual | input | 1 | Manual span mode |
| span_strap | input | 4 | Strapped span value |
| rb_chan | input | 2 | Readback channel select |
| dac_code | output | 64 | Active codes, channel i in bits [16i+15:16i] |
| dac_span | output | 16 | Active spans, channel i in bits [4i+3:4i] |
| integrity_n | output | 1 | Data-integrity flag, low when suspect |
| rb_code | output | 16 | Input code of selected channel |
| rb_span | output | 4 | Input span of selected channel |
| rb_valid | output | 1 | Selected input buffer is trustworthy |

## Verification
A clear and an update can fall in the same cycle. The update can come either from the synchronized load edge or from a command whose frame has just closed. The bench holds `clr_n` low across the whole synchronizer delay of a load pulse, so the load edge is detected while clear is still active. It then checks that every active code stays zero and that the integrity flag stays low. A plain update issued after the clear is released must then restore the preserved input values and raise the flag. This shows that the load was dropped rather than deferred.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_WR_CODE = 3'd1,
        OP_WR_SPAN = 3'd2,
        OP_UPDATE  = 3'd3,
        OP_WR_UPD  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_ABORT,
        ST_EXEC
    } seq_st_e;
endpackage

// File: rtl/qdac_frame_fsm.sv
module qdac_frame_fsm
    import qdac_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              clr_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CODE_W-1:0] cmd_data,
    output logic              exec_o,
    output logic              abort_o,
    output logic [2:0]        lat_op,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [CODE_W-1:0] lat_data
);
    seq_st_e state, state_nx;
    logic    have_cmd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!frame_n) state_nx = clr_n ? ST_FRAME : ST_ABORT;
            end
            ST_FRAME: begin
                if (!clr_n)       state_nx = ST_ABORT;
                else if (frame_n) state_nx = have_cmd ? ST_EXEC : ST_IDLE;
            end
            ST_ABORT: begin
                if (frame_n) state_nx = ST_IDLE;
            end
            ST_EXEC: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_cmd <= 1'b0;
            lat_op   <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (state == ST_IDLE) begin
            have_cmd <= 1'b0;
        end else if (state == ST_FRAME && clr_n && cmd_valid && !frame_n) begin
            have_cmd <= 1'b1;
            lat_op   <= cmd_op;
            lat_addr <= cmd_addr;
            lat_data <= cmd_data;
        end
    end

    // outputs
    always_comb begin
        exec_o  = 1'b0;
        abort_o = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FRAME: abort_o = !clr_n && have_cmd;
            ST_ABORT: ;
            ST_EXEC:  exec_o = 1'b1;
            default:  ;
        endcase
    end

    // R9: a clear inside an open frame never lets that frame execute next cycle
    a_r9_clear_blocks_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !frame_n) |=> !exec_o);
    // R4: execution only directly after the frame was seen high
    a_r4_exec_after_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> $past(frame_n));
endmodule

// File: rtl/qdac_load_sync.sv
module qdac_load_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    output logic load_pulse
);
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[SYNC_STAGES-1:0], load_n};
    end

    assign load_pulse = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];

    // R7: an edge yields a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
    parameter int CODE_W = 16,
    parameter int SPAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              wr_code,
    input  logic              wr_span,
    input  logic              set_inv,
    input  logic              upd_code,
    input  logic              upd_span,
    input  logic [CODE_W-1:0] din,
    input  logic              strap_en,
    input  logic [SPAN_W-1:0] strap,
    output logic [CODE_W-1:0] act_code,
    output logic [SPAN_W-1:0] act_span,
    output logic [CODE_W-1:0] in_code,
    output logic [SPAN_W-1:0] in_span,
    output logic              in_valid
);
    logic [CODE_W-1:0] code_src;
    logic [SPAN_W-1:0] span_src;

    assign code_src = wr_code ? din : in_code;
    assign span_src = strap_en ? strap : (wr_span ? din[SPAN_W-1:0] : in_span);

    // input buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_code  <= '0;
            in_span  <= '0;
            in_valid <= 1'b1;
        end else begin
            if (wr_code) in_code <= din;
            if (wr_span) in_span <= din[SPAN_W-1:0];
            if (set_inv)                 in_valid <= 1'b0;
            else if (wr_code || wr_span) in_valid <= 1'b1;
        end
    end

    // active buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_code <= '0;
            act_span <= '0;
        end else if (!clr_n) begin
            act_code <= '0;
            act_span <= '0;
        end else begin
            if (upd_code) act_code <= code_src;
            if (upd_span) act_span <= span_src;
        end
    end

    // R5: clear zeroes the active buffer and leaves the input buffer intact
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (act_code == '0 && act_span == '0));
    a_r5_input_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> ($stable(in_code) && $stable(in_span)));
    // R3: without an update the active code holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !upd_code) |=> $stable(act_code));
endmodule

// File: rtl/qdac_integrity.sv
module qdac_integrity (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic brownout,
    input  logic upd_ok,
    output logic flag_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 flag_n <= 1'b0;
        else if (!clr_n || brownout) flag_n <= 1'b0;
        else if (upd_ok)            flag_n <= 1'b1;
    end

    // R10: brownout or clear pulls the flag low
    a_r10_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout || !clr_n) |=> !flag_n);
    // R11: the flag rises only after a valid update
    a_r11_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_n) |-> $past(upd_ok));
endmodule

// File: rtl/quad_dac_regcore.sv
module quad_dac_regcore
    import qdac_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CODE_W = 16,
    parameter int SPAN_W = 4,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(N_CH + 1),
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [CODE_W-1:0]        cmd_data,
    input  logic                     clr_n,
    input  logic                     brownout,
    input  logic                     load_n,
    input  logic                     span_manual,
    input  logic [SPAN_W-1:0]        span_strap,
    input  logic [CH_W-1:0]          rb_chan,
    output logic [N_CH*CODE_W-1:0]   dac_code,
    output logic [N_CH*SPAN_W-1:0]   dac_span,
    output logic                     integrity_n,
    output logic [CODE_W-1:0]        rb_code,
    output logic [SPAN_W-1:0]        rb_span,
    output logic                     rb_valid
);
    logic              exec, abort, load_pulse;
    logic [2:0]        lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic [CODE_W-1:0] lat_data;
    logic              is_wrc, is_wrs, is_upd;
    logic [N_CH-1:0]   sel, wrc_v, wrs_v, inv_v, updc_v, upds_v;
    logic              any_upd;
    logic [CODE_W-1:0] in_code_a [N_CH];
    logic [SPAN_W-1:0] in_span_a [N_CH];
    logic [N_CH-1:0]   in_valid_v;

    qdac_frame_fsm #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .clr_n(clr_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .exec_o(exec), .abort_o(abort),
        .lat_op(lat_op), .lat_addr(lat_addr), .lat_data(lat_data)
    );

    qdac_load_sync #(.SYNC_STAGES(SYNC_STAGES)) u_load (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_pulse(load_pulse)
    );

    assign is_wrc = (lat_op == OP_WR_CODE) || (lat_op == OP_WR_UPD);
    assign is_wrs = (lat_op == OP_WR_SPAN);
    assign is_upd = (lat_op == OP_UPDATE) || (lat_op == OP_WR_UPD);

    genvar i;
    generate
        for (i = 0; i < N_CH; i++) begin : g_ch
            assign sel[i]    = (lat_addr == ADDR_W'(i)) || (lat_addr == ADDR_W'(N_CH));
            assign wrc_v[i]  = clr_n && exec && is_wrc && sel[i];
            assign wrs_v[i]  = clr_n && exec && is_wrs && sel[i];
            assign inv_v[i]  = abort && sel[i];
            assign updc_v[i] = clr_n && ((exec && is_upd && sel[i]) || load_pulse);
            assign upds_v[i] = span_manual ? any_upd : updc_v[i];

            qdac_chan #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_chan (
                .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
                .wr_code(wrc_v[i]), .wr_span(wrs_v[i]), .set_inv(inv_v[i]),
                .upd_code(updc_v[i]), .upd_span(upds_v[i]), .din(lat_data),
                .strap_en(span_manual), .strap(span_strap),
                .act_code(dac_code[i*CODE_W +: CODE_W]),
                .act_span(dac_span[i*SPAN_W +: SPAN_W]),
                .in_code(in_code_a[i]), .in_span(in_span_a[i]),
                .in_valid(in_valid_v[i])
            );
        end
    endgenerate

    assign any_upd = |updc_v;

    qdac_integrity u_flag (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .brownout(brownout),
        .upd_ok(any_upd), .flag_n(integrity_n)
    );

    assign rb_code  = in_code_a[rb_chan];
    assign rb_span  = in_span_a[rb_chan];
    assign rb_valid = in_valid_v[rb_chan];

    // R12: clear dominates any concurrent update
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && load_pulse) |=> (dac_code == '0 && !integrity_n));
    // R8: in manual mode an update leaves every span equal to the strap
    a_r8_strap_all: assert property (@(posedge clk) disable iff (!rst_n)
        (span_manual && any_upd && $stable(span_strap)) |=> (dac_span == {N_CH{span_strap}}));
endmodule

// File: tb/quad_dac_regcore_tb.sv
module quad_dac_regcore_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0, cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        clr_n = 1'b1, brownout = 1'b0, load_n = 1'b1;
    logic        span_manual = 1'b0;
    logic [3:0]  span_strap = '0;
    logic [1:0]  rb_chan = '0;
    logic [63:0] dac_code;
    logic [15:0] dac_span;
    logic        integrity_n, rb_valid;
    logic [15:0] rb_code;
    logic [3:0]  rb_span;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    quad_dac_regcore u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .clr_n(clr_n), .brownout(brownout), .load_n(load_n),
        .span_manual(span_manual), .span_strap(span_strap), .rb_chan(rb_chan),
        .dac_code(dac_code), .dac_span(dac_span), .integrity_n(integrity_n),
        .rb_code(rb_code), .rb_span(rb_span), .rb_valid(rb_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] code_of(input int ch);
        return dac_code[ch*16 +: 16];
    endfunction

    function automatic logic [3:0] span_of(input int ch);
        return dac_span[ch*4 +: 4];
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [2:0] addr, input logic [15:0] data);
        @(negedge clk) frame_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; frame_n = 1'b1;
        wait_n(3);
    endtask

    task automatic readback(input int ch);
        rb_chan = 2'(ch);
        #1;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) begin
            chk("R1 span after reset", span_of(c), 0);
            chk("R2 code after reset", code_of(c), 0);
        end
        readback(2);
        chk("R2 rb code reset", rb_code, 0);
        chk("R1 rb span reset", rb_span, 0);
        chk("R2 rb valid reset", rb_valid, 1);
        chk("R10 flag low after reset", integrity_n, 0);
    endtask

    task automatic t_write_then_update;
        send_cmd(3'd1, 3'd1, 16'h1234);
        chk("R3 write leaves output", code_of(1), 0);
        readback(1);
        chk("R3 rb code after write", rb_code, 16'h1234);
        chk("R11 write keeps flag low", integrity_n, 0);
        send_cmd(3'd3, 3'd1, 16'h0);
        chk("R4 update ch1", code_of(1), 16'h1234);
        chk("R4 ch0 untouched", code_of(0), 0);
        chk("R11 flag high after update", integrity_n, 1);
    endtask

    task automatic t_span_and_wrupd;
        send_cmd(3'd2, 3'd2, 16'h0003);
        chk("R3 span write leaves output", span_of(2), 0);
        send_cmd(3'd4, 3'd2, 16'hABCD);
        chk("R4 write-update code", code_of(2), 16'hABCD);
        chk("R4 write-update span", span_of(2), 4'h3);
        chk("R4 other span untouched", span_of(1), 0);
    endtask

    task automatic t_broadcast;
        send_cmd(3'd1, 3'd4, 16'h0F0F);
        send_cmd(3'd3, 3'd4, 16'h0);
        for (int c = 0; c < 4; c++) chk("R4 broadcast code", code_of(c), 16'h0F0F);
        chk("R4 broadcast keeps span", span_of(2), 4'h3);
    endtask

    task automatic t_clear_and_load;
        @(negedge clk) clr_n = 1'b0;
        wait_n(2);
        clr_n = 1'b1;
        wait_n(1);
        for (int c = 0; c < 4; c++) chk("R5 clear zero code", code_of(c), 0);
        chk("R5 clear zero span", span_of(2), 0);
        chk("R10 flag low after clear", integrity_n, 0);
        readback(1);
        chk("R5 input kept", rb_code, 16'h0F0F);
        send_cmd(3'd3, 3'd6, 16'h0);
        send_cmd(3'd0, 3'd0, 16'h0);
        chk("R4 bad address no update", code_of(0), 0);
        chk("R11 nop/bad addr keeps flag low", integrity_n, 0);
        @(negedge clk) load_n = 1'b0;
        wait_n(4);
        load_n = 1'b1;
        wait_n(2);
        for (int c = 0; c < 4; c++) chk("R6 R7 load restores", code_of(c), 16'h0F0F);
        chk("R6 span restored", span_of(2), 4'h3);
        chk("R11 flag high after load", integrity_n, 1);
    endtask

    task automatic t_abort;
        @(negedge clk) frame_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 3'd0; cmd_data = 16'h5555;
        @(negedge clk);
        cmd_valid = 1'b0; clr_n = 1'b0;
        @(negedge clk) clr_n = 1'b1;
        @(negedge clk) frame_n = 1'b1;
        wait_n(3);
        chk("R9 aborted cmd not run", code_of(0), 0);
        readback(0);
        chk("R9 aborted buffer invalid", rb_valid, 0);
        chk("R9 input code not written", rb_code, 16'h0F0F);
        readback(1);
        chk("R9 other buffer valid", rb_valid, 1);
        chk("R10 flag low after abort clear", integrity_n, 0);
    endtask

    task automatic t_brownout;
        send_cmd(3'd3, 3'd1, 16'h0);
        chk("R11 flag high before brownout", integrity_n, 1);
        @(negedge clk) brownout = 1'b1;
        @(negedge clk) brownout = 1'b0;
        chk("R10 brownout drops flag", integrity_n, 0);
        chk("R10 brownout keeps code", code_of(1), 16'h0F0F);
        send_cmd(3'd3, 3'd1, 16'h0);
        chk("R11 flag back after update", integrity_n, 1);
    endtask

    task automatic t_collision;
        @(negedge clk) clr_n = 1'b0;
        load_n = 1'b0;
        wait_n(5);
        load_n = 1'b1;
        wait_n(3);
        clr_n = 1'b1;
        wait_n(2);
        for (int c = 0; c < 4; c++) chk("R12 load under clear dropped", code_of(c), 0);
        chk("R12 flag stays low", integrity_n, 0);
        send_cmd(3'd3, 3'd4, 16'h0);
        chk("R6 update restores after clear", code_of(3), 16'h0F0F);
        chk("R11 flag high", integrity_n, 1);
    endtask

    task automatic t_manual;
        span_manual = 1'b1; span_strap = 4'h5;
        send_cmd(3'd4, 3'd3, 16'h7777);
        for (int c = 0; c < 4; c++) chk("R8 strap span all channels", span_of(c), 4'h5);
        chk("R8 code only addressed", code_of(3), 16'h7777);
        chk("R8 other code kept", code_of(0), 16'h0F0F);
        readback(3);
        chk("R8 input span untouched", rb_span, 0);
        span_manual = 1'b0;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_write_then_update();
        t_span_and_wrupd();
        t_broadcast();
        t_clear_and_load();
        t_abort();
        t_brownout();
        t_collision();
        t_manual();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule